// File: doc/BRIEF.md
# Receive Queue Scheduler with Age and Length Discard

This block sits between four receive descriptor queues and one host-facing output. Producers push frame descriptors into per-queue FIFOs, and the block presents one descriptor at a time to the host. The host takes it with a ready signal. A software select register sets which queues may be served. Among the queues that are enabled and hold entries, the highest-numbered queue always wins.

Each queue can also be set to discard its head entry on its own. A discard happens when the queue reaches a programmable length threshold or when its head has waited longer than a programmable age limit. The lowest queue is never trimmed for length, only for age.

Ages come from a free-running tick counter with a programmable prescale. Each entry records the tick value when it is enqueued. A read-only status word reports occupancy and over-threshold flags for every queue.

Top module: `rxq_sched`

## Requirements
- R1: Select register (address 0) bit q enables queue q for service. A queue whose bit is 0 is never presented on the output. It still accepts pushes, which is visible in the status not-empty bit. `out_valid` is high exactly when some enabled queue holds an entry.
- R2: Among enabled non-empty queues, the one with the highest index is granted (3 over 2 over 1 over 0), and `out_qid` carries its index.
- R3: `out_desc` is the oldest entry of the granted queue. On a cycle with `out_valid` and `pop_ready` both high, that entry is removed at the clock edge. Each queue delivers entries in push order.
- R4: Select register bit 4+q enables discarding for queue q. With that bit 0, queue q never raises `drop_pulse[q]` and never loses an entry except by a pop.
- R5: For queue q in 1..3 with discarding enabled, holding at least one entry and with occupancy greater than or equal to its threshold (address 4+q, 5 bits), the head entry is discarded at the edge. `drop_pulse[q]` is high during that cycle, and at most one entry per queue is discarded per cycle.
- R6: Queue 0 is never discarded for length, whatever its threshold.
- R7: The tick counter advances by one, modulo 128, on every cycle where the prescale counter is greater than or equal to the prescale register (address 3); the prescale counter then returns to 0. On any other cycle the prescale counter increments instead. An entry's age is the current tick minus its enqueue tick, modulo 128. A discard-enabled queue drops its head when that age is greater than the 6-bit age limit (address 2).
- R8: The entry being popped in a cycle is never discarded in that same cycle.
- R9: A push to a queue holding 16 entries is refused, leaving the queue unchanged, and `ovf_pulse[q]` is high during that cycle.
- R10: Address 1 reads the status word: bit q is queue q not-empty, and bit 4+q is queue q occupancy greater than or equal to its threshold. Writes to address 1 are ignored.
- R11: After reset: select is 0, age limit is 63, prescale is 0, all thresholds are 16, and all queues are empty. Addresses 0, 2, 3 and 4..7 read back their register values, zero-extended to 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 4 | Per-queue push request |
| push_desc | input | 64 | Per-queue descriptor, queue q in bits [16q+15:16q] |
| pop_ready | input | 1 | Host accepts the presented descriptor |
| out_valid | output | 1 | A descriptor is presented |
| out_qid | output | 2 | Index of the granted queue |
| out_desc | output | 16 | Head descriptor of the granted queue |
| drop_pulse | output | 4 | Head discarded this cycle, per queue |
| ovf_pulse | output | 4 | Push refused because the queue is full, per queue |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |

## Verification
The stimulus runs in phases.

- A directed phase with every queue blocked and discarding off fills all FIFOs. This exercises refusal on a full queue and shows that blocked queues still store entries.
- Random phases then vary push density, pop readiness and register writes. Changing select masks separates the priority order from plain gating.
- Small age limits with short prescales make age discards dominate.
- Small thresholds make length discards dominate. This tells queue 0's exemption apart from the others, and shows whether a popped head is spared a discard.

A per-cycle model predicts every output and every register read.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned NQ_DEF = 4;
  localparam logic [2:0] A_SEL    = 3'd0;
  localparam logic [2:0] A_STATUS = 3'd1;
  localparam logic [2:0] A_AGE    = 3'd2;
  localparam logic [2:0] A_PRESC  = 3'd3;
  localparam logic       A_THR_HI = 1'b1; // addresses 4..7 hold thresholds
endpackage

// File: rtl/rxq_age_timer.sv
module rxq_age_timer #(
  parameter int unsigned TW = 7,
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] prescale,
  output logic [TW-1:0] tick
);
  logic [PW-1:0] pc_q, pc_d;
  logic [TW-1:0] tick_d;
  logic          adv;

  always_comb begin
    adv    = (pc_q >= prescale);
    pc_d   = adv ? '0 : pc_q + 1'b1;
    tick_d = adv ? tick + 1'b1 : tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      tick <= '0;
    end else begin
      pc_q <= pc_d;
      tick <= tick_d;
    end
  end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int unsigned W     = 23,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_d;
  logic          full, wr_ok;

  always_comb begin
    full  = (count == CW'(DEPTH));
    wr_ok = wr_req && !full;
    ovf   = wr_req && full;
    wp_d  = wr_ok ? wp_q + 1'b1 : wp_q;
    rp_d  = rd_en ? rp_q + 1'b1 : rp_q;
    cnt_d = count + CW'(wr_ok) - CW'(rd_en);
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      count <= cnt_d;
    end
  end

  assign rd_data = mem[rp_q];
endmodule

// File: rtl/rxq_arbiter.sv
module rxq_arbiter #(
  parameter int unsigned NQ = 4,
  localparam int unsigned QW = $clog2(NQ)
) (
  input  logic [NQ-1:0] req,
  output logic          gnt_valid,
  output logic [QW-1:0] gnt_idx
);
  always_comb begin
    gnt_valid = |req;
    gnt_idx   = '0;
    for (int i = 0; i < NQ; i++) begin
      if (req[i]) gnt_idx = QW'(i);
    end
  end
endmodule

// File: rtl/rxq_sched.sv
module rxq_sched #(
  parameter int unsigned NQ    = rxq_pkg::NQ_DEF,
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TW    = 7,
  parameter int unsigned PW    = 8,
  localparam int unsigned QW   = $clog2(NQ),
  localparam int unsigned CW   = $clog2(DEPTH) + 1,
  localparam int unsigned AGW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NQ-1:0]    push_valid,
  input  logic [NQ*DW-1:0] push_desc,
  input  logic             pop_ready,
  output logic             out_valid,
  output logic [QW-1:0]    out_qid,
  output logic [DW-1:0]    out_desc,
  output logic [NQ-1:0]    drop_pulse,
  output logic [NQ-1:0]    ovf_pulse,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata
);
  import rxq_pkg::*;

  logic [NQ-1:0]  sel_en, sel_en_d, flush_en, flush_en_d;
  logic [AGW-1:0] age_lim, age_lim_d;
  logic [PW-1:0]  presc, presc_d;
  logic [CW-1:0]  thr_q [NQ];
  logic [CW-1:0]  thr_d [NQ];

  logic [TW-1:0]  tick;
  logic [DW-1:0]  head_desc [NQ];
  logic [TW-1:0]  head_stamp [NQ];
  logic [CW-1:0]  q_cnt [NQ];
  logic [NQ-1:0]  q_nonempty, q_long, q_old, q_pop, q_remove;
  logic           pop_fire;

  // register next-state
  always_comb begin
    sel_en_d   = sel_en;
    flush_en_d = flush_en;
    age_lim_d  = age_lim;
    presc_d    = presc;
    for (int i = 0; i < NQ; i++) thr_d[i] = thr_q[i];
    if (reg_wr) begin
      if (reg_addr[2] == A_THR_HI) begin
        thr_d[reg_addr[QW-1:0]] = reg_wdata[CW-1:0];
      end else begin
        case (reg_addr)
          A_SEL: begin
            sel_en_d   = reg_wdata[NQ-1:0];
            flush_en_d = reg_wdata[2*NQ-1:NQ];
          end
          A_AGE:   age_lim_d = reg_wdata[AGW-1:0];
          A_PRESC: presc_d   = reg_wdata[PW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_en   <= '0;
      flush_en <= '0;
      age_lim  <= '1;
      presc    <= '0;
      for (int i = 0; i < NQ; i++) thr_q[i] <= CW'(DEPTH);
    end else begin
      sel_en   <= sel_en_d;
      flush_en <= flush_en_d;
      age_lim  <= age_lim_d;
      presc    <= presc_d;
      for (int i = 0; i < NQ; i++) thr_q[i] <= thr_d[i];
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr[2] == A_THR_HI) begin
      reg_rdata = 8'(thr_q[reg_addr[QW-1:0]]);
    end else begin
      case (reg_addr)
        A_SEL:    reg_rdata = {flush_en, sel_en};
        A_STATUS: reg_rdata = {q_long, q_nonempty};
        A_AGE:    reg_rdata = 8'(age_lim);
        A_PRESC:  reg_rdata = 8'(presc);
        default:  reg_rdata = '0;
      endcase
    end
  end

  rxq_age_timer #(.TW(TW), .PW(PW)) timer_i (
    .clk(clk), .rst_n(rst_n), .prescale(presc), .tick(tick)
  );

  rxq_arbiter #(.NQ(NQ)) arb_i (
    .req(sel_en & q_nonempty), .gnt_valid(out_valid), .gnt_idx(out_qid)
  );

  assign pop_fire = out_valid && pop_ready;
  assign out_desc = head_desc[out_qid];

  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic [TW-1:0] age;

    rxq_fifo #(.W(DW + TW), .DEPTH(DEPTH)) fifo_i (
      .clk(clk), .rst_n(rst_n),
      .wr_req(push_valid[g]),
      .wr_data({push_desc[g*DW +: DW], tick}),
      .rd_en(q_remove[g]),
      .rd_data({head_desc[g], head_stamp[g]}),
      .count(q_cnt[g]),
      .ovf(ovf_pulse[g])
    );

    assign q_nonempty[g] = (q_cnt[g] != '0);
    assign q_long[g]     = (q_cnt[g] >= thr_q[g]);
    assign age           = tick - head_stamp[g];
    assign q_old[g]      = q_nonempty[g] && (age > TW'(age_lim));
    assign q_pop[g]      = pop_fire && (out_qid == QW'(g));

    if (g == 0) begin : g_age_only
      assign drop_pulse[g] = flush_en[g] && q_old[g] && !q_pop[g];
    end else begin : g_age_len
      assign drop_pulse[g] = flush_en[g] && q_nonempty[g] &&
                             (q_old[g] || q_long[g]) && !q_pop[g];
    end

    assign q_remove[g] = q_pop[g] || drop_pulse[g];
  end
endmodule

// File: rtl/rxq_sched_chk.sv
module rxq_sched_chk #(
  parameter int unsigned NQ = 4,
  localparam int unsigned QW = $clog2(NQ)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic [QW-1:0] out_qid,
  input logic          pop_ready,
  input logic [NQ-1:0] drop_pulse,
  input logic [NQ-1:0] ovf_pulse,
  input logic [NQ-1:0] push_valid,
  input logic [NQ-1:0] sel_en,
  input logic [NQ-1:0] flush_en,
  input logic [NQ-1:0] q_nonempty
);
  // R1
  grant_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sel_en[out_qid] && q_nonempty[out_qid]));

  // R1
  idle_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_en & q_nonempty) == '0) |-> !out_valid);

  // R2
  highest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((sel_en & q_nonempty) >> out_qid) == NQ'(1)));

  // R4
  drop_needs_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_pulse & ~flush_en) == '0);

  // R8
  no_drop_popped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pop_ready) |-> !drop_pulse[out_qid]);

  // R5
  drop_only_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_pulse & ~q_nonempty) == '0);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse & ~push_valid) == '0);
endmodule

bind rxq_sched rxq_sched_chk #(.NQ(NQ)) chk_i (.*);

// File: tb/rxq_sched_tb_top.sv
module rxq_sched_tb_top;
  localparam int NQ = 4, DW = 16, DEPTH = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic [NQ-1:0]    push_valid;
  logic [NQ*DW-1:0] push_desc;
  logic             pop_ready;
  logic             out_valid;
  logic [1:0]       out_qid;
  logic [DW-1:0]    out_desc;
  logic [NQ-1:0]    drop_pulse, ovf_pulse;
  logic             reg_wr;
  logic [2:0]       reg_addr;
  logic [7:0]       reg_wdata, reg_rdata;

  rxq_sched dut_i (.*);

  int total = 0, bad = 0;
  bit done = 0;

  int m_cnt[NQ], m_hd[NQ], m_thr[NQ];
  int m_desc[NQ][DEPTH], m_stamp[NQ][DEPTH];
  int m_sel, m_fl, m_age, m_pre, m_pc, m_tick;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_rdata(input int a);
    int s;
    case (a)
      0: return (m_fl << 4) | m_sel;
      1: begin
        s = 0;
        for (int q = 0; q < NQ; q++) begin
          if (m_cnt[q] > 0) s |= (1 << q);
          if (m_cnt[q] >= m_thr[q]) s |= (1 << (q + 4));
        end
        return s;
      end
      2: return m_age;
      3: return m_pre;
      default: return m_thr[a - 4];
    endcase
  endfunction

  function automatic int best_q(input int elig);
    int g = -1;
    for (int q = 0; q < NQ; q++) if (elig[q]) g = q;
    return g;
  endfunction

  task automatic model_reset();
    for (int q = 0; q < NQ; q++) begin
      m_cnt[q] = 0; m_hd[q] = 0; m_thr[q] = 16;
    end
    m_sel = 0; m_fl = 0; m_age = 63; m_pre = 0; m_pc = 0; m_tick = 0;
  endtask

  // inputs are driven; compare at mid-cycle, then advance the model to the edge
  task automatic step();
    int elig, g, hd0, cnt0, idx, age;
    bit popped, tl, old, dr;
    string tg;
    #1;
    elig = 0;
    for (int q = 0; q < NQ; q++) if (m_sel[q] && m_cnt[q] > 0) elig |= (1 << q);
    g = best_q(elig);
    chk("R1 out_valid", int'(out_valid), int'(g >= 0));
    if (g >= 0) begin
      chk("R2 out_qid", int'(out_qid), g);
      chk("R3 out_desc", int'(out_desc), m_desc[g][m_hd[g]]);
    end
    popped = (g >= 0) && pop_ready;
    chk(reg_addr == 3'd1 ? "R10 status" : "R11 readback", int'(reg_rdata), exp_rdata(int'(reg_addr)));
    for (int q = 0; q < NQ; q++) begin
      tl  = m_cnt[q] >= m_thr[q];
      age = (m_tick - m_stamp[q][m_hd[q]]) & 127;
      old = (m_cnt[q] > 0) && (age > m_age);
      dr  = m_fl[q] && (m_cnt[q] > 0) && (old || (q != 0 && tl)) && !(popped && g == q);
      if (!m_fl[q]) tg = "R4 drop";
      else if (popped && g == q) tg = "R8 drop";
      else if (old) tg = "R7 drop";
      else if (q == 0) tg = "R6 drop";
      else tg = "R5 drop";
      chk(tg, int'(drop_pulse[q]), int'(dr));
      chk("R9 ovf", int'(ovf_pulse[q]), int'(push_valid[q] && m_cnt[q] == DEPTH));
      hd0 = m_hd[q]; cnt0 = m_cnt[q];
      if ((popped && g == q) || dr) begin
        m_hd[q] = (m_hd[q] + 1) % DEPTH;
        m_cnt[q]--;
      end
      if (push_valid[q] && cnt0 < DEPTH) begin
        idx = (hd0 + cnt0) % DEPTH;
        m_desc[q][idx]  = int'(push_desc[q*DW +: DW]);
        m_stamp[q][idx] = m_tick;
        m_cnt[q]++;
      end
    end
    if (m_pc >= m_pre) begin m_pc = 0; m_tick = (m_tick + 1) & 127; end
    else m_pc++;
    if (reg_wr) begin
      case (reg_addr)
        3'd0: begin m_sel = reg_wdata[3:0]; m_fl = reg_wdata[7:4]; end
        3'd1: ;
        3'd2: m_age = reg_wdata & 63;
        3'd3: m_pre = reg_wdata;
        default: m_thr[reg_addr - 4] = reg_wdata & 31;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_idle();
    push_valid = '0; push_desc = '0; pop_ready = 1'b0;
    reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
  endtask

  task automatic wr(input int a, input int d);
    drive_idle();
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    step();
  endtask

  task automatic rnd_cycle(input int pp, input int pr, input int wp, input int amax);
    int a;
    for (int q = 0; q < NQ; q++) begin
      push_valid[q] = ($urandom % 100) < pp;
      push_desc[q*DW +: DW] = DW'($urandom);
    end
    pop_ready = ($urandom % 100) < pr;
    a = $urandom % 8;
    reg_addr = 3'(a);
    reg_wr = ($urandom % 100) < wp;
    case (a)
      2: reg_wdata = 8'($urandom % (amax + 1));
      3: reg_wdata = 8'($urandom % 4);
      4, 5, 6, 7: reg_wdata = 8'($urandom % 20);
      default: reg_wdata = 8'($urandom);
    endcase
    step();
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    drive_idle();
    model_reset();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset out_valid", int'(out_valid), 0);
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a); #1;
      chk("R11 reset reg", int'(reg_rdata), exp_rdata(a));
    end
    reg_addr = 3'd0;
    rst_n = 1'b1;
    @(negedge clk);

    // directed: all blocked, discard off, fill to overflow (R1, R9)
    for (int c = 0; c < 20; c++) begin
      drive_idle();
      push_valid = '1;
      push_desc = {16'(c + 300), 16'(c + 200), 16'(c + 100), 16'(c)};
      pop_ready = 1'b1;
      reg_addr = 3'd1;
      step();
    end
    // status write ignored (R10)
    wr(1, 8'h00);
    drive_idle(); reg_addr = 3'd1; step();
    // enable Q1 only, drain a few in order (R3)
    wr(0, 8'h02);
    for (int c = 0; c < 5; c++) begin drive_idle(); pop_ready = 1'b1; step(); end
    // enable all, priority (R2)
    wr(0, 8'h0F);
    for (int c = 0; c < 8; c++) begin drive_idle(); pop_ready = 1'b1; step(); end
    // length discard with Q0 exemption (R5, R6)
    wr(4, 2); wr(5, 2); wr(6, 2); wr(7, 2);
    wr(0, 8'hF0);
    for (int c = 0; c < 20; c++) begin drive_idle(); reg_addr = 3'd1; step(); end

    // random phases: push%, pop%, write%, max age limit
    for (int c = 0; c < 1500; c++) rnd_cycle(40, 50, 6, 20);
    for (int c = 0; c < 1500; c++) rnd_cycle(70, 15, 4, 8);
    for (int c = 0; c < 1500; c++) rnd_cycle(30, 80, 8, 63);
    for (int c = 0; c < 1500; c++) rnd_cycle(90, 40, 3, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule